// File: doc/BRIEF.md
# Capped Multi-Thread Issue Slot Allocator

This block shares a fixed set of issue slots among several hardware threads in every cycle. The default is eight slots and eight threads. Each thread reports how many of its instructions are ready to issue, an age tag for its oldest ready instruction, and whether that head instruction is a branch. A mode input limits how many slots a single thread may take in one cycle: one, two, four, or no limit. The block ranks the threads by an ordering policy. The thread ranked first takes as many slots as its ready count and the cap allow, then the next thread takes from what remains, and so on down the ranking.

There are two ordering policies. The first is age order: the lowest age tag wins, and on equal tags the lower thread index wins. The second puts threads whose head instruction is a branch ahead of all others, and uses age order within each group. The block also reports how many slots went unused in the cycle, so that utilization can be monitored. The decision is combinational on the inputs sampled at a clock edge, and the grant counts and the idle count are registered at that edge.

Top module: `slot_issue_alloc`

## Requirements
- R1: While reset (active low, synchronous) is sampled low, every grant output is 0 and the idle output equals the slot count (8).
- R2: A thread's grant never exceeds the ready count it presented.
- R3: A thread's grant never exceeds the cap selected by the 2-bit mode: 2'b00 allows 1, 2'b01 allows 2, 2'b10 allows 4, and 2'b11 allows all 8 slots.
- R4: The grants of all threads together never exceed 8.
- R5: The idle output equals 8 minus the sum of all grants for the same cycle.
- R6: With the order select at 0, threads are served in increasing age tag. On equal tags the lower thread index is served first. A thread receives a slot only after every thread ranked ahead of it has received min(ready, cap).
- R7: With the order select at 1, every thread whose head-branch flag is 1 is ranked ahead of every thread whose flag is 0. Age order as in R6 applies within each group.
- R8: If any thread receives less than min(ready, cap), all 8 slots are granted in that cycle.
- R9: In mode 2'b11, a single thread with 8 or more ready instructions takes all 8 slots.
- R10: In mode 2'b01, four threads each with at least 2 ready instructions fill all 8 slots, 2 each.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge. Inputs that change between edges do not alter the outputs before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ready_cnt_i | input | NUM_THREADS x RDY_W | Ready instruction count for each thread |
| head_age_i | input | NUM_THREADS x AGE_W | Age tag of each thread's oldest ready instruction (lower is older) |
| head_branch_i | input | NUM_THREADS | 1 when that thread's head instruction is a branch |
| cap_mode_i | input | 2 | Per-thread issue cap: 00=1, 01=2, 10=4, 11=unlimited |
| order_sel_i | input | 1 | Ordering policy: 0 = age order, 1 = branches first |
| grant_o | output | NUM_THREADS x GNT_W | Registered number of slots granted to each thread |
| idle_o | output | GNT_W | Registered number of slots left unused |

## Verification
Two limits can act in the same cycle: the per-thread cap and the exhaustion of the shared slot budget. The bench provokes this with a cap of two or four while more threads are ready than the slots can hold. It also runs mixed random cycles with narrow age ranges, so that tie-breaks and branch promotion coincide with those limits. Each cycle is judged against a behavioural model that sorts the threads by key and hands out slots greedily. The checker independently confirms that a lower-ranked thread gets a slot only when every thread ahead of it has been fully served.

// File: rtl/slot_alloc_pkg.sv
// Shared types and helpers for the issue slot allocator.
// Assumes the cap encodings below are the only mode values used.
package slot_alloc_pkg;

    typedef enum logic [1:0] {
        CAP_ONE  = 2'b00,
        CAP_TWO  = 2'b01,
        CAP_FOUR = 2'b10,
        CAP_NONE = 2'b11
    } cap_mode_e;

    typedef enum logic {
        ORD_AGE    = 1'b0,
        ORD_BRANCH = 1'b1
    } order_sel_e;

    // Slot limit for one thread under a cap mode, clipped to the slot count.
    function automatic int unsigned cap_of(cap_mode_e mode, int unsigned slots);
        int unsigned lim;
        case (mode)
            CAP_ONE:  lim = 1;
            CAP_TWO:  lim = 2;
            CAP_FOUR: lim = 4;
            default:  lim = slots;
        endcase
        return (lim > slots) ? slots : lim;
    endfunction

endpackage

// File: rtl/slot_want.sv
// Computes, for each thread, the number of slots it would take if
// nothing ranked ahead of it: min(ready count, active cap).
// Assumes GNT_W can hold NUM_SLOTS.
module slot_want
    import slot_alloc_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SLOTS   = 8,
    parameter int RDY_W       = 4,
    parameter int GNT_W       = 4
) (
    input  logic [NUM_THREADS-1:0][RDY_W-1:0] ready_cnt,
    input  cap_mode_e                         cap_mode,
    output logic [NUM_THREADS-1:0][GNT_W-1:0] want
);

    localparam int CW = ((RDY_W > GNT_W) ? RDY_W : GNT_W) + 1;

    logic [CW-1:0] cap_w;

    // Widen the active cap to the comparison width.
    always_comb begin
        cap_w = CW'(cap_of(cap_mode, NUM_SLOTS));
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic [CW-1:0] rdy_w;
        logic [CW-1:0] lim_w;

        // Clip this thread's ready count to the cap.
        always_comb begin
            rdy_w   = CW'(ready_cnt[t]);
            lim_w   = (rdy_w < cap_w) ? rdy_w : cap_w;
            want[t] = lim_w[GNT_W-1:0];
        end
    end

endmodule

// File: rtl/slot_rank.sv
// Builds a strict precedence matrix between threads: ahead[j][i] is 1
// when thread j is served before thread i. Under branch order a thread
// with a branch at its head precedes one without; otherwise the lower
// age tag wins, and the lower index breaks ties. Assumes age tags are
// comparable without wrap.
module slot_rank
    import slot_alloc_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int AGE_W       = 6
) (
    input  logic [NUM_THREADS-1:0][AGE_W-1:0] head_age,
    input  logic [NUM_THREADS-1:0]            head_branch,
    input  order_sel_e                        order_sel,
    output logic [NUM_THREADS-1:0][NUM_THREADS-1:0] ahead
);

    // Evaluate every ordered pair of threads.
    always_comb begin
        for (int j = 0; j < NUM_THREADS; j++) begin
            for (int i = 0; i < NUM_THREADS; i++) begin
                if (j == i) begin
                    ahead[j][i] = 1'b0;
                end else if (order_sel == ORD_BRANCH &&
                             head_branch[j] != head_branch[i]) begin
                    ahead[j][i] = head_branch[j];
                end else if (head_age[j] != head_age[i]) begin
                    ahead[j][i] = head_age[j] < head_age[i];
                end else begin
                    ahead[j][i] = (j < i);
                end
            end
        end
    end

endmodule

// File: rtl/slot_fill.sv
// Hands out slots greedily along the precedence order: each thread gets
// min(want, slots not claimed by threads ahead of it). Also reports the
// number of slots left over. Assumes the precedence matrix is a strict
// total order.
module slot_fill #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SLOTS   = 8,
    parameter int GNT_W       = 4
) (
    input  logic [NUM_THREADS-1:0][GNT_W-1:0]       want,
    input  logic [NUM_THREADS-1:0][NUM_THREADS-1:0] ahead,
    output logic [NUM_THREADS-1:0][GNT_W-1:0]       grant,
    output logic [GNT_W-1:0]                        idle
);

    localparam int SUM_W = $clog2(NUM_THREADS * NUM_SLOTS + 1) + 1;
    localparam logic [SUM_W-1:0] SLOTS_S = SUM_W'(NUM_SLOTS);

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
        logic [SUM_W-1:0] claimed;
        logic [SUM_W-1:0] room;
        logic [SUM_W-1:0] want_s;

        // Sum the demand of all threads ranked ahead of thread i.
        always_comb begin
            claimed = '0;
            for (int j = 0; j < NUM_THREADS; j++) begin
                if (ahead[j][i]) begin
                    claimed = claimed + SUM_W'(want[j]);
                end
            end
        end

        // Grant what is left, up to this thread's own demand.
        always_comb begin
            room     = (claimed >= SLOTS_S) ? '0 : (SLOTS_S - claimed);
            want_s   = SUM_W'(want[i]);
            grant[i] = (want_s < room) ? want[i] : room[GNT_W-1:0];
        end
    end

    logic [SUM_W-1:0] total;

    // Count granted slots and derive the unused remainder.
    always_comb begin
        total = '0;
        for (int k = 0; k < NUM_THREADS; k++) begin
            total = total + SUM_W'(grant[k]);
        end
        idle = GNT_W'(SLOTS_S - total);
    end

endmodule

// File: rtl/slot_issue_alloc.sv
// Top of the issue slot allocator. Caps each thread's demand, ranks the
// threads by the selected policy, fills the slots greedily and registers
// the per-thread grants and the idle count. Assumes the inputs are stable
// around the rising edge; the result appears one edge later.
module slot_issue_alloc
    import slot_alloc_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SLOTS   = 8,
    parameter int RDY_W       = 4,
    parameter int AGE_W       = 6,
    localparam int GNT_W      = $clog2(NUM_SLOTS + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_THREADS-1:0][RDY_W-1:0] ready_cnt_i,
    input  logic [NUM_THREADS-1:0][AGE_W-1:0] head_age_i,
    input  logic [NUM_THREADS-1:0]            head_branch_i,
    input  logic [1:0]                        cap_mode_i,
    input  logic                              order_sel_i,
    output logic [NUM_THREADS-1:0][GNT_W-1:0] grant_o,
    output logic [GNT_W-1:0]                  idle_o
);

    cap_mode_e                               cap_mode;
    order_sel_e                              order_sel;
    logic [NUM_THREADS-1:0][GNT_W-1:0]       want;
    logic [NUM_THREADS-1:0][NUM_THREADS-1:0] ahead;
    logic [NUM_THREADS-1:0][GNT_W-1:0]       grant_d;
    logic [GNT_W-1:0]                        idle_d;

    // Map the raw control pins onto their enumerated meanings.
    always_comb begin
        cap_mode  = cap_mode_e'(cap_mode_i);
        order_sel = order_sel_e'(order_sel_i);
    end

    slot_want #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_SLOTS   (NUM_SLOTS),
        .RDY_W       (RDY_W),
        .GNT_W       (GNT_W)
    ) u_want (
        .ready_cnt (ready_cnt_i),
        .cap_mode  (cap_mode),
        .want      (want)
    );

    slot_rank #(
        .NUM_THREADS (NUM_THREADS),
        .AGE_W       (AGE_W)
    ) u_rank (
        .head_age    (head_age_i),
        .head_branch (head_branch_i),
        .order_sel   (order_sel),
        .ahead       (ahead)
    );

    slot_fill #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_SLOTS   (NUM_SLOTS),
        .GNT_W       (GNT_W)
    ) u_fill (
        .want  (want),
        .ahead (ahead),
        .grant (grant_d),
        .idle  (idle_d)
    );

    // Register the allocation once per cycle; reset clears all grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o <= '0;
            idle_o  <= GNT_W'(NUM_SLOTS);
        end else begin
            grant_o <= grant_d;
            idle_o  <= idle_d;
        end
    end

endmodule

// File: rtl/slot_issue_alloc_chk.sv
// Property checker for the issue slot allocator. It keeps its own copy
// of the inputs from the previous edge and judges the registered outputs
// against them. Attached to every instance of the top by bind.
module slot_issue_alloc_chk
    import slot_alloc_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SLOTS   = 8,
    parameter int RDY_W       = 4,
    parameter int AGE_W       = 6,
    localparam int GNT_W      = $clog2(NUM_SLOTS + 1)
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_THREADS-1:0][RDY_W-1:0] ready_cnt_i,
    input logic [NUM_THREADS-1:0][AGE_W-1:0] head_age_i,
    input logic [NUM_THREADS-1:0]            head_branch_i,
    input logic [1:0]                        cap_mode_i,
    input logic                              order_sel_i,
    input logic [NUM_THREADS-1:0][GNT_W-1:0] grant_o,
    input logic [GNT_W-1:0]                  idle_o
);

    localparam int SW = 16;

    logic                              live_q;
    logic [NUM_THREADS-1:0][RDY_W-1:0] rdy_q;
    logic [NUM_THREADS-1:0][AGE_W-1:0] age_q;
    logic [NUM_THREADS-1:0]            br_q;
    logic [1:0]                        mode_q;
    logic                              ord_q;

    // Capture the inputs the current outputs were computed from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            rdy_q  <= '0;
            age_q  <= '0;
            br_q   <= '0;
            mode_q <= '0;
            ord_q  <= 1'b0;
        end else begin
            live_q <= 1'b1;
            rdy_q  <= ready_cnt_i;
            age_q  <= head_age_i;
            br_q   <= head_branch_i;
            mode_q <= cap_mode_i;
            ord_q  <= order_sel_i;
        end
    end

    logic [SW-1:0]                 gsum;
    logic [SW-1:0]                 cap_q;
    logic [NUM_THREADS-1:0][SW-1:0] full_q;
    logic                          short_any;

    // Totals, caps and full-service demand derived from captured inputs.
    always_comb begin
        gsum      = '0;
        cap_q     = SW'(cap_of(cap_mode_e'(mode_q), NUM_SLOTS));
        short_any = 1'b0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            gsum      = gsum + SW'(grant_o[t]);
            full_q[t] = (SW'(rdy_q[t]) < cap_q) ? SW'(rdy_q[t]) : cap_q;
            if (SW'(grant_o[t]) < full_q[t]) short_any = 1'b1;
        end
    end

    a_r4_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gsum <= SW'(NUM_SLOTS));

    a_r5_idle_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (SW'(idle_o) + gsum) == SW'(NUM_SLOTS));

    a_r8_no_waste: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && short_any) |-> gsum == SW'(NUM_SLOTS));

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        a_r2_within_ready: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |-> SW'(grant_o[t]) <= SW'(rdy_q[t]));

        a_r3_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |-> SW'(grant_o[t]) <= cap_q);

        for (genvar u = 0; u < NUM_THREADS; u++) begin : g_pair
            if (t != u) begin : g_ne
                logic t_first;
                // Thread t precedes thread u under the captured policy (R6, R7).
                always_comb begin
                    if (ord_q && br_q[t] != br_q[u]) t_first = br_q[t];
                    else if (age_q[t] != age_q[u])   t_first = age_q[t] < age_q[u];
                    else                             t_first = (t < u);
                end

                a_r6_r7_served_first: assert property (@(posedge clk) disable iff (!rst_n)
                    (live_q && t_first && grant_o[u] != '0) |->
                        SW'(grant_o[t]) == full_q[t]);
            end
        end
    end

endmodule

bind slot_issue_alloc slot_issue_alloc_chk #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_SLOTS   (NUM_SLOTS),
    .RDY_W       (RDY_W),
    .AGE_W       (AGE_W)
) u_chk (.*);

// File: tb/slot_issue_alloc_tb_top.sv
// Bench for the issue slot allocator: a sort-and-fill reference model is
// compared with the registered outputs on every clock.
module slot_issue_alloc_tb_top;

    localparam int NT = 8;
    localparam int NS = 8;
    localparam int RW = 4;
    localparam int AW = 6;
    localparam int GW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                    rst_n;
    logic [NT-1:0][RW-1:0]   rdy;
    logic [NT-1:0][AW-1:0]   age;
    logic [NT-1:0]           br;
    logic [1:0]              mode;
    logic                    ord;
    logic [NT-1:0][GW-1:0]   gnt;
    logic [GW-1:0]           idle;

    int checks = 0;
    int fails  = 0;
    int exp_g[NT];
    int exp_idle;

    slot_issue_alloc #(.NUM_THREADS(NT), .NUM_SLOTS(NS), .RDY_W(RW), .AGE_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ready_cnt_i(rdy), .head_age_i(age),
        .head_branch_i(br), .cap_mode_i(mode), .order_sel_i(ord),
        .grant_o(gnt), .idle_o(idle)
    );

    // Reference: sort threads by key, then hand out slots in that order.
    task automatic model();
        int order[NT];
        int key[NT];
        int cap, left, w, g, tmp;
        for (int t = 0; t < NT; t++) exp_g[t] = 0;
        if (!rst_n) begin
            exp_idle = NS;
            return;
        end
        cap = (mode == 2'b00) ? 1 : (mode == 2'b01) ? 2 : (mode == 2'b10) ? 4 : NS;
        for (int t = 0; t < NT; t++) begin
            order[t] = t;
            key[t] = ((ord && br[t]) ? 0 : 1000000) + int'(age[t]) * 100 + t;
        end
        for (int a = 0; a < NT; a++) begin
            for (int b = 0; b < NT - 1 - a; b++) begin
                if (key[order[b]] > key[order[b+1]]) begin
                    tmp = order[b]; order[b] = order[b+1]; order[b+1] = tmp;
                end
            end
        end
        left = NS;
        for (int k = 0; k < NT; k++) begin
            w = int'(rdy[order[k]]);
            if (w > cap) w = cap;
            g = (w < left) ? w : left;
            exp_g[order[k]] = g;
            left -= g;
        end
        exp_idle = left;
    endtask

    // One clock: predict, let an edge pass, compare at the falling edge.
    task automatic cyc(string tag);
        model();
        @(negedge clk);
        for (int t = 0; t < NT; t++) begin
            checks++;
            if (int'(gnt[t]) != exp_g[t]) begin
                fails++;
                $display("FAIL %s grant[%0d] actual=%0d expected=%0d", tag, t, gnt[t], exp_g[t]);
            end
        end
        checks++;
        if (int'(idle) != exp_idle) begin
            fails++;
            $display("FAIL %s idle actual=%0d expected=%0d", tag, idle, exp_idle);
        end
    endtask

    // Directed check of one grant against a hand-worked value.
    task automatic chk_g(string tag, int t, int val);
        checks++;
        if (int'(gnt[t]) != val) begin
            fails++;
            $display("FAIL %s grant[%0d] actual=%0d expected=%0d", tag, t, gnt[t], val);
        end
    endtask

    task automatic chk_idle(string tag, int val);
        checks++;
        if (int'(idle) != val) begin
            fails++;
            $display("FAIL %s idle actual=%0d expected=%0d", tag, idle, val);
        end
    endtask

    task automatic clear();
        rdy = '0; age = '0; br = '0;
    endtask

    initial begin
        rst_n = 1'b0; clear(); mode = 2'b11; ord = 1'b0;
        @(negedge clk);
        rdy[0] = 4'd5;
        cyc("R1 reset");
        cyc("R1 reset");
        chk_idle("R1 reset", NS);
        rst_n = 1'b1;

        clear(); mode = 2'b11; rdy[3] = 4'd9; age[3] = 6'd12;
        cyc("R9 single thread");
        chk_g("R9", 3, 8); chk_idle("R9", 0);

        clear(); mode = 2'b01;
        for (int t = 0; t < NT; t += 2) begin rdy[t] = 4'd5; age[t] = 6'(t); end
        #2;
        chk_g("R11 hold before edge", 3, 8);
        cyc("R10 cap two");
        for (int t = 0; t < NT; t += 2) chk_g("R10", t, 2);
        chk_idle("R10", 0);

        clear(); mode = 2'b00;
        for (int t = 0; t < NT; t++) rdy[t] = 4'd3;
        cyc("R3 cap one");
        chk_g("R3", 7, 1); chk_idle("R3", 0);

        clear(); mode = 2'b10; rdy[1] = 4'd6; rdy[5] = 4'd6; rdy[2] = 4'd6; age[2] = 6'd50;
        cyc("R3 cap four");
        chk_g("R3", 1, 4); chk_g("R3", 5, 4); chk_g("R3", 2, 0);

        clear(); mode = 2'b11; rdy[2] = 4'd2; rdy[7] = 4'd1;
        cyc("R2 R5 light load");
        chk_g("R2", 2, 2); chk_g("R2", 7, 1); chk_idle("R5", 5);

        clear(); mode = 2'b01; rdy[3] = 4'd5; rdy[4] = 4'd5;
        cyc("R5 R8 cap limited");
        chk_idle("R5", 4);

        clear(); mode = 2'b11; rdy[5] = 4'd6; age[5] = 6'd1; rdy[2] = 4'd6; age[2] = 6'd3;
        cyc("R6 age order");
        chk_g("R6", 5, 6); chk_g("R6", 2, 2);

        clear(); rdy[1] = 4'd5; rdy[6] = 4'd5; age[1] = 6'd7; age[6] = 6'd7;
        cyc("R6 tie");
        chk_g("R6 tie", 1, 5); chk_g("R6 tie", 6, 3);

        clear(); ord = 1'b1; rdy[4] = 4'd6; age[4] = 6'd40; br[4] = 1'b1;
        rdy[0] = 4'd6; age[0] = 6'd2;
        cyc("R7 branch first");
        chk_g("R7", 4, 6); chk_g("R7", 0, 2);
        ord = 1'b0;
        cyc("R7 policy off");
        chk_g("R7 off", 0, 6); chk_g("R7 off", 4, 2);

        rst_n = 1'b0;
        cyc("R1 mid-run reset");
        chk_g("R1", 0, 0); chk_idle("R1", NS);
        rst_n = 1'b1;

        for (int n = 0; n < 400; n++) begin
            for (int t = 0; t < NT; t++) begin
                rdy[t] = RW'($urandom % 16);
                age[t] = AW'((n % 2 == 0) ? ($urandom % 4) : ($urandom % 64));
                br[t]  = 1'($urandom % 3 == 0);
            end
            mode = 2'($urandom % 4);
            ord  = 1'($urandom % 2);
            cyc("R2 R3 R4 R5 R6 R7 R8 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule